// File: doc/BRIEF.md
# Two-Level Trigger Latency Buffer

This block holds a stream of detector samples until two successive trigger decisions have been made about them. A new sample arrives on every clock. The first stage is a fixed-latency delay line built on a dual-port RAM. A free-running counter writes every sample into the RAM. The read address is that counter plus a constant offset, modulo the depth, so each sample comes out a fixed number of cycles after it went in. That fixed latency matches the time the first-level trigger takes to decide.

When a first-level accept strobe is high, the word now leaving the delay line is copied into a small second RAM. That RAM is run as a ring with its own write and read pointers. Entries wait there for the second-level decision. A second-level "yes" removes the oldest entry and presents it on the output for one cycle, with a valid flag. A second-level "no" removes the oldest entry silently. An occupancy count guards the ring. Two sticky flags record an accept that found the ring full and a decision that found the ring empty.

Using RAM for both stages keeps the storage at depth times width: 360 bits at the default sizes. A shift pipeline long enough to cover the whole second-level latency would need far more.

Top module: `trig_latency_buf`

## Requirements
- R1: A first-level accept raised in cycle m captures the sample that was presented in cycle m-DLY. DLY is the delay parameter (default 9, which must be less than the delay RAM depth of 10). Captures are only meaningful once DLY cycles have passed since reset.
- R2: An accept that finds fewer than BUF_DEPTH (default 8) entries stored appends its word. Words leave in the order they were appended, and the occupancy never exceeds BUF_DEPTH.
- R3: A "yes" decision in cycle m with at least one entry stored removes the oldest entry. After the clock edge that ends cycle m, that word is on data_o and valid_o is high for exactly one cycle.
- R4: A "no" decision with at least one entry stored removes the oldest entry, and valid_o stays low in the following cycle.
- R5: An accept that finds BUF_DEPTH entries stored is dropped and sets overflow_o, which stays high until reset.
- R6: A decision of either kind that finds the ring empty sets underflow_o, which stays high until reset. It removes nothing and does not raise valid_o.
- R7: An accept and a decision in the same cycle are both judged on the occupancy from before that cycle. With the ring neither empty nor full, both take effect and the occupancy is unchanged.
- R8: When the "yes" and "no" inputs are high together, the decision counts as a single "yes".
- R9: Reset (rst_n low) clears both ring pointers, the occupancy, both flags, valid_o and data_o. The RAM contents are not cleared, and valid_o stays low until a "yes" finds a stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | DATA_W | New detector sample, one per cycle |
| l0_accept_i | input | 1 | First-level accept for the word leaving the delay line |
| l2_yes_i | input | 1 | Second-level keep decision for the oldest stored entry |
| l2_no_i | input | 1 | Second-level discard decision for the oldest stored entry |
| data_o | output | DATA_W | Last word delivered by a keep decision |
| valid_o | output | 1 | One-cycle flag marking a fresh word on data_o |
| overflow_o | output | 1 | Sticky flag: an accept found the ring full |
| underflow_o | output | 1 | Sticky flag: a decision found the ring empty |

## Verification
The hardest conditions to reach are the ring boundaries combined with strobes in the same cycle. Examples are an accept and a decision arriving together while the ring is exactly full, or exactly empty. Both pointers must also wrap correctly while the delay-line counter sits at an unrelated phase.

Directed sequences fill the ring to capacity and push one more accept. They then drain it past empty and repeat the simultaneous strobes at each edge. A long random run follows, with accept and decision rates close enough that the occupancy wanders across the full range many times. Each sample is a random word remembered by its cycle index, so any off-by-one in the delay or in the ring order shows up as a wrong word.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_DROP = 2'd1,
        DEC_KEEP = 2'd2
    } l2_dec_e;

    // keep wins when both strobes are high
    function automatic l2_dec_e decode_l2(input logic yes, input logic no);
        if (yes)     return DEC_KEEP;
        else if (no) return DEC_DROP;
        else         return DEC_NONE;
    endfunction

endpackage

// File: rtl/tlb_dpram.sv
module tlb_dpram #(
    parameter int W     = 20,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) assert_waddr_range_R2: assert (int'(waddr) < DEPTH);
    end
endmodule

// File: rtl/tlb_delay_line.sv
module tlb_delay_line #(
    parameter int W     = 20,
    parameter int DEPTH = 10,
    parameter int DLY   = 9,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OFS  = DEPTH - DLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] delayed_o
);
    typedef struct packed {
        logic [AW-1:0] wr;
    } dl_state_t;

    dl_state_t     st_d, st_q;
    logic [AW:0]   sum;
    logic [AW-1:0] rd_addr;

    always_comb begin
        st_d    = st_q;
        st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        sum     = {1'b0, st_q.wr} + (AW + 1)'(OFS);
        rd_addr = (sum >= (AW + 1)'(DEPTH)) ? AW'(sum - (AW + 1)'(DEPTH)) : AW'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tlb_dpram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (1'b1),
        .waddr (st_q.wr),
        .wdata (sample_i),
        .raddr (rd_addr),
        .rdata (delayed_o)
    );

    // R1: both addresses stay inside the RAM, and the read lags by DLY
    assert_wr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.wr) < DEPTH);
    assert_rd_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < DEPTH);
    assert_counter_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.wr) != DEPTH - 1) |=> (st_q.wr == $past(st_q.wr) + 1'b1));
endmodule

// File: rtl/tlb_decision_buf.sv
module tlb_decision_buf
    import tlb_pkg::*;
#(
    parameter int W     = 20,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    input  logic         l0_accept_i,
    input  logic         l2_yes_i,
    input  logic         l2_no_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         overflow_o,
    output logic         underflow_o
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
        logic          valid;
        logic [W-1:0]  data;
    } db_state_t;

    db_state_t st_d, st_q;
    l2_dec_e   dec;
    logic      full, empty, do_wr, do_rd;
    logic [W-1:0] rdata;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        dec   = decode_l2(l2_yes_i, l2_no_i);
        full  = (st_q.cnt == CW'(DEPTH));
        empty = (st_q.cnt == '0);
        do_wr = l0_accept_i && !full;
        do_rd = (dec != DEC_NONE) && !empty;

        if (l0_accept_i && full)         st_d.ovf = 1'b1;
        if ((dec != DEC_NONE) && empty)  st_d.unf = 1'b1;

        if (do_wr) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_rd) st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;

        if (do_rd && (dec == DEC_KEEP)) begin
            st_d.valid = 1'b1;
            st_d.data  = rdata;
        end

        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tlb_dpram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (do_wr),
        .waddr (st_q.wr),
        .wdata (word_i),
        .raddr (st_q.rd),
        .rdata (rdata)
    );

    assign data_o      = st_q.data;
    assign valid_o     = st_q.valid;
    assign overflow_o  = st_q.ovf;
    assign underflow_o = st_q.unf;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH);
    assert_valid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(l2_yes_i && (st_q.cnt != '0)));
    assert_no_is_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_no_i && !l2_yes_i) |=> !st_q.valid);
    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    assert_overflow_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(l0_accept_i && (st_q.cnt == CW'(DEPTH))));
    assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf |=> st_q.unf);
    assert_empty_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |=> !st_q.valid);
    assert_balanced_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_accept_i && (l2_yes_i || l2_no_i) && (st_q.cnt != '0)
         && (st_q.cnt != CW'(DEPTH))) |=> $stable(st_q.cnt));
    assert_both_is_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_yes_i && l2_no_i && (st_q.cnt != '0)) |=> st_q.valid);
endmodule

// File: rtl/trig_latency_buf.sv
module trig_latency_buf #(
    parameter int DATA_W    = 20,
    parameter int DLY_DEPTH = 10,
    parameter int DLY       = 9,
    parameter int BUF_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              l0_accept_i,
    input  logic              l2_yes_i,
    input  logic              l2_no_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              overflow_o,
    output logic              underflow_o
);
    logic [DATA_W-1:0] delayed;

    tlb_delay_line #(.W(DATA_W), .DEPTH(DLY_DEPTH), .DLY(DLY)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .delayed_o (delayed)
    );

    tlb_decision_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (delayed),
        .l0_accept_i (l0_accept_i),
        .l2_yes_i    (l2_yes_i),
        .l2_no_i     (l2_no_i),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    initial begin
        assert_param_order_R1: assert (DLY > 0 && DLY < DLY_DEPTH);
    end
endmodule

// File: tb/trig_latency_buf_bench.sv
module trig_latency_buf_bench;
    localparam int DW  = 20;
    localparam int DLD = 10;
    localparam int DLY = 9;
    localparam int BD  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] sample_i;
    logic          l0_accept_i, l2_yes_i, l2_no_i;
    logic [DW-1:0] data_o;
    logic          valid_o, overflow_o, underflow_o;

    always #5 clk = ~clk;

    trig_latency_buf #(.DATA_W(DW), .DLY_DEPTH(DLD), .DLY(DLY), .BUF_DEPTH(BD))
    u_trig_latency_buf (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .l0_accept_i(l0_accept_i), .l2_yes_i(l2_yes_i), .l2_no_i(l2_no_i),
        .data_o(data_o), .valid_o(valid_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    int unsigned   n_chk = 0, n_bad = 0;
    bit            finished = 0;
    int            m = 0;
    logic [DW-1:0] hist [64];
    logic [DW-1:0] q [$];
    logic          e_valid, e_ovf, e_unf;
    logic [DW-1:0] e_data;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at step %0d: actual %0h expected %0h", req, what, m, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; l0_accept_i = 0; l2_yes_i = 0; l2_no_i = 0; sample_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m = 0; q.delete();
        e_valid = 0; e_ovf = 0; e_unf = 0; e_data = '0;
        chk("R9", "valid after reset", 32'(valid_o), 0);
        chk("R9", "overflow after reset", 32'(overflow_o), 0);
        chk("R9", "underflow after reset", 32'(underflow_o), 0);
        chk("R9", "data after reset", 32'(data_o), 0);
    endtask

    // one cycle: drive at negedge, model, then check at the following negedge
    task automatic step(input string req, input bit l0, input bit yes, input bit no);
        logic [DW-1:0] s;
        int            pre;
        s = DW'($urandom);
        sample_i = s; l0_accept_i = l0; l2_yes_i = yes; l2_no_i = no;
        hist[m % 64] = s;
        pre = q.size();
        e_valid = 0;
        if (yes || no) begin
            if (pre == 0) e_unf = 1;
            else begin
                if (yes) begin e_valid = 1; e_data = q[0]; end
                void'(q.pop_front());
            end
        end
        if (l0) begin
            if (pre == BD) e_ovf = 1;
            else q.push_back(hist[(m - DLY) % 64]);
        end
        @(posedge clk);
        @(negedge clk);
        m++;
        chk(req, "valid", 32'(valid_o), 32'(e_valid));
        if (e_valid) chk(req, "data", 32'(data_o), 32'(e_data));
        chk(req, "overflow", 32'(overflow_o), 32'(e_ovf));
        chk(req, "underflow", 32'(underflow_o), 32'(e_unf));
        l0_accept_i = 0; l2_yes_i = 0; l2_no_i = 0;
    endtask

    initial begin
        void'($urandom(32'd7391));
        reset_dut();
        // R9: no output without a keep decision
        for (int i = 0; i < DLY + 3; i++) step("R9", 0, 0, 0);
        // R1 / R3 / R4: basic capture, keep and discard
        step("R1", 1, 0, 0);
        step("R1", 0, 0, 0);
        step("R1", 1, 0, 0);
        step("R2", 1, 0, 0);
        step("R3", 0, 1, 0);
        step("R4", 0, 0, 1);
        step("R3", 0, 1, 0);
        step("R3", 0, 0, 0);
        // R5: fill to capacity, one more accept, then simultaneous at full
        for (int i = 0; i < BD; i++) step("R2", 1, 0, 0);
        step("R5", 1, 0, 0);
        step("R7", 1, 1, 0);
        step("R5", 0, 0, 0);
        // R8: both strobes counted as keep
        step("R8", 0, 1, 1);
        // R6: drain past empty, including simultaneous at empty
        for (int i = 0; i < BD - 1; i++) step("R4", 0, 0, 1);
        step("R6", 1, 1, 0);
        step("R6", 0, 0, 1);
        // R9: reset clears sticky flags
        reset_dut();
        for (int i = 0; i < DLY; i++) step("R9", 0, 0, 0);
        // R7: balanced strobes in the middle of the ring
        step("R7", 1, 0, 0);
        step("R7", 1, 0, 0);
        for (int i = 0; i < 6; i++) step("R7", 1, (i % 2) == 0, (i % 2) == 1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit a, y, n;
            r = int'($urandom_range(99));
            a = (r < 45);
            r = int'($urandom_range(99));
            y = (r < 22);
            n = (r >= 22 && r < 42) || (r >= 97);
            step("R2", a, y, n);
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at step %0d: actual hung expected done", m);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule